// File: doc/BRIEF.md
# Timer/Event Counter with Reload

An up-counting timer/event counter for a small controller. Software programs a reload value and a control byte over a simple register bus. The counter then advances from one of three sources:

- prescaled internal clock ticks;
- edges on an external input;
- prescaled ticks counted only while the external input holds its active level.

When the counter passes its all-ones value it reloads from the reload register and emits a one-cycle overflow event. That event drives a wake-up pulse and, when enabled, an interrupt request. It also toggles a divide-by-two frequency output.

Writes of the reload value behave in one of two ways. While the counter is stopped, the write lands in the counter immediately. While it runs, the write waits in the reload register until the next overflow. A counter read suppresses any count step in that cycle, so the value read out is never caught mid-change. In pulse-width mode the block clears its own run bit at the end of the measured pulse. The count left behind is the pulse length in prescaled ticks.

Top module: `tmr_evt_unit`

## Requirements
- R1: After synchronous reset the counter, reload register and control byte are 0, and `irq`, `wake` and `pfd_out` are low.
- R2: Control byte layout: bits 7:6 select the mode (00 idle, 01 event count, 10 timer, 11 pulse width); bit 5 inverts the active level of `evt_in`; bit 4 is run; bit 3 enables the interrupt; bits 2:0 select the prescaler. The byte is written with `wr_sel`=1 and reads back on `rd_data` when `rd_sel`=1.
- R3: A counter write (`wr_sel`=0) while run is 0 loads both the reload register and the counter at that edge.
- R4: A counter write while run is 1 changes only the reload register, and counting continues. An overflow reloads the newest reload value, including a value written at the overflow edge itself.
- R5: A count step taken at all-ones loads the reload value, and `wake` is high for exactly the following cycle.
- R6: In timer mode the counter steps once every 2^S clock cycles, where S is control bits 2:0. The prescaler runs freely from reset.
- R7: In a cycle with `rd_en`=1 and `rd_sel`=0, no count step occurs and the step is lost.
- R8: `pfd_out` toggles once per overflow, in the same cycle that `wake` is high.
- R9: `irq` is high for the cycle after an overflow only if the interrupt-enable bit was 1 at that edge.
- R10: In event mode the counter steps once per transition of `evt_in` into its active level. The transition takes effect after a two-flop synchronizer.
- R11: In pulse-width mode the counter takes prescaled steps while the synchronized input is active. The transition out of the active level clears run.
- R12: With mode idle or run 0, the counter changes only through writes. In timer and event modes, run is cleared only by a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 counter/reload, 1 control |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (a counter read holds the count) |
| rd_sel | input | 1 | Read source: 0 counter, 1 control |
| rd_data | output | 8 | Read data, combinational from `rd_sel` |
| evt_in | input | 1 | External event / pulse input, asynchronous |
| irq | output | 1 | Interrupt request pulse |
| wake | output | 1 | Wake-up pulse on every overflow |
| pfd_out | output | 1 | Overflow rate divided by two |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a counter read and a count step. The bench issues counter reads back to back during timer and pulse counting. It expects the counter to freeze for those cycles and the skipped steps never to be recovered.

The second pair is a running reload write and an overflow. The bench times a reload write to the exact edge at which the counter sits at all-ones. It judges the reload by the value read back one cycle later and by the `wake` and `pfd_out` pulses that follow.

// File: rtl/tmr_pkg.sv
// Shared types for the timer/event counter.
// Assumes an 8-bit control byte whose field positions are fixed by software.
package tmr_pkg;

    localparam int TMR_PS_SEL_W = 3;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e                 mode;
        logic                      act_low;
        logic                      run;
        logic                      irq_en;
        logic [TMR_PS_SEL_W-1:0]   ps_sel;
    } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescale.sv
// Free-running prescaler: tick is high one cycle in every 2^sel cycles.
// Assumes sel is at most SEL_W bits wide; the counter width follows from it.
module tmr_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W:0]   one_hot;
    logic [CNT_W-1:0] mask;

    // Divider counter, reset to zero, wraps freely.
    always_ff @(posedge clk) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    // Low sel bits of the counter all ones marks the tick.
    always_comb begin
        one_hot = (CNT_W+1)'(1) << sel;
        mask    = one_hot[CNT_W-1:0] - 1'b1;
        if (one_hot[CNT_W]) mask = '1;
        tick    = ((div_cnt & mask) == mask);
    end
endmodule

// File: rtl/tmr_edge_sync.sv
// Synchronizes the external input and reports its active level and its
// entry to / exit from that level. Polarity is applied after the flops.
// Assumes STAGES >= 1.
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic invert,
    output logic level,
    output logic lead,
    output logic trail
);
    logic [STAGES:0] chain;
    logic            prev_level;

    // Shift the raw input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], din};
    end

    // Level and transitions in the active sense.
    always_comb begin
        level      = chain[STAGES-1] ^ invert;
        prev_level = chain[STAGES] ^ invert;
        lead       = level & ~prev_level;
        trail      = ~level & prev_level;
    end
endmodule

// File: rtl/tmr_count_core.sv
// Counter and reload register. A load while stopped goes to both; while
// running it goes only to the reload register. A step at all ones reloads,
// using a reload value written in that same cycle.
// Assumes step is only asserted while running.
module tmr_count_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         load,
    input  logic         running,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] reload_q;
    logic [W-1:0] reload_nx;

    // Reload value seen by this cycle's overflow.
    always_comb begin
        reload_nx = load ? load_val : reload_q;
        ovf       = step && (&cnt);
    end

    // Reload register update.
    always_ff @(posedge clk) begin
        if (!rst_n) reload_q <= '0;
        else        reload_q <= reload_nx;
    end

    // Counter: direct load when stopped, else step or reload.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load && !running) cnt <= load_val;
        else if (ovf)              cnt <= reload_nx;
        else if (step)             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_evt_unit.sv
// Timer/event counter top: control byte, step selection by mode, read hold,
// pulse-width auto stop and registered overflow outputs.
// Assumes W >= 8 so the control byte fits the read path.
module tmr_evt_unit
    import tmr_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    input  logic         rd_sel,
    output logic [W-1:0] rd_data,
    input  logic         evt_in,
    output logic         irq,
    output logic         wake,
    output logic         pfd_out
);
    tmr_ctrl_t    ctrl_q;
    logic         ps_tick;
    logic         in_level, in_lead, in_trail;
    logic         hold, step, pw_done, ovf;
    logic         cnt_load;
    logic [W-1:0] cnt_val;

    tmr_prescale #(.SEL_W(TMR_PS_SEL_W)) u_ps (
        .clk(clk), .rst_n(rst_n), .sel(ctrl_q.ps_sel), .tick(ps_tick)
    );

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(evt_in), .invert(ctrl_q.act_low),
        .level(in_level), .lead(in_lead), .trail(in_trail)
    );

    tmr_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .step(step), .load(cnt_load),
        .running(ctrl_q.run), .load_val(wr_data), .cnt(cnt_val), .ovf(ovf)
    );

    // Step source per mode, gated by run and by a counter read.
    always_comb begin
        hold     = rd_en && !rd_sel;
        cnt_load = wr_en && !wr_sel;
        step     = 1'b0;
        unique case (ctrl_q.mode)
            MODE_EVENT: step = in_lead;
            MODE_TIMER: step = ps_tick;
            MODE_PULSE: step = ps_tick && in_level;
            default:    step = 1'b0;
        endcase
        step    = step && ctrl_q.run && !hold;
        pw_done = ctrl_q.run && (ctrl_q.mode == MODE_PULSE) && in_trail;
    end

    // Control byte: software write wins over the pulse-width auto stop.
    always_ff @(posedge clk) begin
        if (!rst_n)               ctrl_q     <= '0;
        else if (wr_en && wr_sel) ctrl_q     <= tmr_ctrl_t'(wr_data[7:0]);
        else if (pw_done)         ctrl_q.run <= 1'b0;
    end

    // Registered overflow consequences.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            wake    <= 1'b0;
            pfd_out <= 1'b0;
        end else begin
            irq     <= ovf && ctrl_q.irq_en;
            wake    <= ovf;
            pfd_out <= pfd_out ^ ovf;
        end
    end

    // Read mux.
    always_comb begin
        rd_data = rd_sel ? W'(ctrl_q) : cnt_val;
    end
endmodule

// File: rtl/tmr_evt_chk.sv
// Assertion checker for tmr_evt_unit, attached by bind below.
module tmr_evt_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         wr_sel,
    input logic [W-1:0] wr_data,
    input logic         rd_en,
    input logic         rd_sel,
    input logic         irq,
    input logic         wake,
    input logic         pfd_out,
    input logic [W-1:0] cnt,
    input logic         run,
    input logic [1:0]   mode,
    input logic         irq_en
);
    assert_stopped_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && !wr_sel && !run) |-> cnt == $past(wr_data));

    assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en && !rd_sel && !(wr_en && !wr_sel)) |-> cnt == $past(cnt));

    assert_pfd_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> pfd_out != $past(pfd_out));

    assert_pfd_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wake |-> pfd_out == $past(pfd_out));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> wake && $past(irq_en));

    assert_auto_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(wr_en && wr_sel) || $past(mode) == 2'b11);

    assert_idle_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past((mode == 2'b00 || !run) && !(wr_en && !wr_sel)) |-> cnt == $past(cnt));
endmodule

bind tmr_evt_unit tmr_evt_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .irq(irq),
    .wake(wake), .pfd_out(pfd_out), .cnt(cnt_val), .run(ctrl_q.run),
    .mode(ctrl_q.mode), .irq_en(ctrl_q.irq_en)
);

// File: tb/sim_tmr_evt_unit.sv
// Bench: behavioural reference model updated at each rising edge, compared
// at every falling edge against all outputs.
module sim_tmr_evt_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       evt_in = 1'b0;
    logic [7:0] rd_data;
    logic       irq, wake, pfd_out;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";

    // Model state
    int m_cnt, m_pre, m_ctrl, m_ps;
    bit m_s1, m_s2, m_s3, m_irq, m_wake, m_pfd;

    always #10 clk = ~clk;

    tmr_evt_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .evt_in(evt_in), .irq(irq), .wake(wake), .pfd_out(pfd_out)
    );

    // Reference model, one update per rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_ctrl = 0; m_ps = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_irq = 0; m_wake = 0; m_pfd = 0;
        end else begin
            int  mode, div;
            bit  inv, run, lvl, plvl, tick, adv, ov;
            mode = (m_ctrl >> 6) & 3;
            inv  = m_ctrl[5];
            run  = m_ctrl[4];
            div  = 1 << (m_ctrl & 7);
            lvl  = m_s2 ^ inv;
            plvl = m_s3 ^ inv;
            tick = (m_ps % div) == div - 1;
            case (mode)
                1: adv = lvl && !plvl;
                2: adv = tick;
                3: adv = tick && lvl;
                default: adv = 0;
            endcase
            adv = adv && run && !(rd_en && !rd_sel);
            ov  = adv && m_cnt == 255;
            if (wr_en && !wr_sel) m_pre = wr_data;
            if (wr_en && !wr_sel && !run) m_cnt = wr_data;
            else if (ov)  m_cnt = m_pre;
            else if (adv) m_cnt = m_cnt + 1;
            m_irq  = ov && m_ctrl[3];
            m_wake = ov;
            if (ov) m_pfd = !m_pfd;
            if (wr_en && wr_sel) m_ctrl = wr_data;
            else if (run && mode == 3 && !lvl && plvl) m_ctrl = m_ctrl & ~32'h10;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt_in;
            m_ps = (m_ps + 1) % 128;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One clock: compare registered outputs, drive inputs, compare read data.
    task automatic cyc(input bit we, input bit ws, input [7:0] wd, input bit re, input bit rs);
        @(negedge clk);
        check("R9", "irq", irq, m_irq);
        check("R5", "wake", wake, m_wake);
        check("R8", "pfd_out", pfd_out, m_pfd);
        wr_en = we; wr_sel = ws; wr_data = wd; rd_en = re; rd_sel = rs;
        #1;
        check(rs ? "R2" : cur_req, rs ? "ctrl" : "count", rd_data, rs ? m_ctrl : m_cnt);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic wr_ctrl(input [7:0] v);
        cyc(1, 1, v, 0, 1);
        cyc(0, 0, 0, 0, 1);
    endtask

    task automatic wr_cnt(input [7:0] v);
        cyc(1, 0, v, 0, 0);
    endtask

    task automatic pulse_evt(input int hi, input int lo);
        evt_in = ~evt_in; idle(hi);
        evt_in = ~evt_in; idle(lo);
    endtask

    bit finished = 0;

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1"; cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 1);
        // R3: load while stopped
        cur_req = "R3"; wr_cnt(8'hF0); idle(3);
        // R5 R8 R9: timer, prescale 1, irq on
        cur_req = "R5"; wr_ctrl(8'h98); idle(40);
        // R4: running write, then write exactly at overflow edge
        cur_req = "R4"; wr_cnt(8'hFA); idle(30);
        while (m_cnt != 255) idle(1);
        wr_cnt(8'hF8); idle(12);
        // R7: back-to-back counter reads freeze the count
        cur_req = "R7";
        for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, 0);
        for (int i = 0; i < 20; i++) cyc(0, 0, 0, i % 3 == 0, 0);
        // R9: interrupt disabled
        cur_req = "R9"; wr_ctrl(8'h90); idle(30);
        // R6: prescale by 4 and by 128
        cur_req = "R6"; wr_ctrl(8'h82); wr_cnt(8'hF8); wr_ctrl(8'h9A); idle(60);
        wr_ctrl(8'h9F); idle(600);
        // R12: software stop, then idle mode with run set
        cur_req = "R12"; wr_ctrl(8'h88); idle(10);
        wr_ctrl(8'h18); for (int i = 0; i < 4; i++) pulse_evt(3, 3);
        // R10: event mode, both polarities
        cur_req = "R10"; wr_ctrl(8'h48); wr_cnt(8'hFD); wr_ctrl(8'h58);
        for (int i = 0; i < 6; i++) pulse_evt(3, 4);
        pulse_evt(1, 1); pulse_evt(2, 1);
        wr_ctrl(8'h78);
        for (int i = 0; i < 5; i++) pulse_evt(4, 3);
        // R11: pulse width, active high, prescale 2
        cur_req = "R11"; evt_in = 0; wr_ctrl(8'hC8); wr_cnt(8'h00); wr_ctrl(8'hD9);
        evt_in = 1; idle(30);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 0);
        evt_in = 0; idle(8); cyc(0, 0, 0, 0, 1);
        // R11: active low, crossing an overflow
        wr_ctrl(8'hE8); wr_cnt(8'hF0); evt_in = 1; idle(3);
        wr_ctrl(8'hF8); evt_in = 0; idle(25);
        evt_in = 1; idle(8); cyc(0, 0, 0, 0, 1);
        // Mixed stimulus
        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            bit we = ($urandom % 8) == 0;
            bit ws = ($urandom % 3) == 0;
            evt_in = $urandom % 2;
            cyc(we, ws, ws ? 8'($urandom) | 8'h10 : 8'($urandom), ($urandom % 5) == 0, ($urandom % 4) == 0);
        end
        idle(4);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule